// File: doc/BRIEF.md
# Sense-Reversing Barrier Unit

This block holds a group of P processors at a common meeting point. Each processor raises its arrive line for one cycle when it reaches the barrier. The unit counts the arrivals in a shared counter. When the count reaches P, it clears the counter and flips a global flag. In the cycle after that, every waiting processor sees its depart line pulse. After the pulse it may go on to its next barrier at once.

Each processor has a private sense bit that toggles every time one of its arrivals is accepted. A processor is released when the global flag equals its own sense bit. The flag takes the value of the new sense at the end of each episode. Because of this, back-to-back episodes need no clearing step between them. A processor that has left one episode and arrives at the next one cannot disturb a slower processor that is still being released from the previous episode. Arrivals from several processors in the same cycle are summed by a population-count adder, so they all count in that cycle.

Top module: `barrier_sync_unit`

## Requirements
- R1: After reset no depart line is asserted, and no processor counts as waiting.
- R2: An arrive pulse from a processor that is not waiting is accepted. It marks that processor waiting, toggles its sense bit and adds one to the episode count.
- R3: Arrivals from several processors in the same cycle are all counted in that cycle.
- R4: When an accepted arrival brings the episode count to P, the counter returns to 0 and the global flag flips. In the next cycle every one of the P processors has its depart line high.
- R5: While fewer than P processors are waiting, no depart line is asserted.
- R6: An arrive pulse from a processor that is already waiting, including one in its depart cycle, is ignored. It adds nothing to the count and does not change its sense bit.
- R7: A processor may arrive in the cycle right after its depart pulse. Successive episodes complete correctly with no reset between them.
- R8: A depart pulse lasts exactly one cycle, after which that processor is no longer waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arrive_i | input | P | One-cycle arrival pulse per processor (bit i for processor i) |
| depart_o | output | P | Release pulse per processor (bit i for processor i) |

## Verification
The checks inside the design assume that arrive_i is held low while reset is asserted. They also assume that arrive_i is a clean synchronous signal, so the counter and flag checks are not defeated by arrivals that make no sense. The stimulus drives arrive_i only on falling edges and keeps it at zero throughout reset. The stimulus also deliberately repeats arrivals from processors that are already waiting, including in the release cycle. This exercises the ignore rule without breaking what the checks assume.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  // width of a counter that must hold values 0..n inclusive
  function automatic int count_width(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction
endpackage

// File: rtl/arrival_popcount.sv
module arrival_popcount #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic [N-1:0]  bits_i,
  output logic [CW-1:0] sum_o
);
  always_comb begin
    sum_o = '0;
    for (int k = 0; k < N; k++) begin
      sum_o = sum_o + CW'(bits_i[k]);
    end
  end
endmodule

// File: rtl/sense_slot.sv
module sense_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arrive_i,
  input  logic flag_i,
  output logic accept_o,
  output logic depart_o
);
  logic sense_q, sense_d;
  logic wait_q, wait_d;
  logic en;

  assign accept_o = arrive_i & ~wait_q;
  assign depart_o = wait_q & (flag_i == sense_q);
  assign en       = accept_o | depart_o;

  always_comb begin
    sense_d = sense_q;
    wait_d  = wait_q;
    if (accept_o) begin
      sense_d = ~sense_q;
      wait_d  = 1'b1;
    end else if (depart_o) begin
      wait_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= 1'b0;
      wait_q  <= 1'b0;
    end else if (en) begin
      sense_q <= sense_d;
      wait_q  <= wait_d;
    end
  end

  // R6
  wait_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && arrive_i) |=> $stable(sense_q));
  // R8
  depart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depart_o |=> !depart_o);
  // R2
  accept_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (sense_q != $past(sense_q)));
endmodule

// File: rtl/episode_ctrl.sv
module episode_ctrl #(
  parameter int P  = 4,
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] add_i,
  output logic          flag_o,
  output logic          done_o
);
  localparam logic [CW:0] FULL = (CW+1)'(P);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic [CW:0]   sum;
  logic          en;

  assign sum    = {1'b0, cnt_q} + {1'b0, add_i};
  assign done_o = (sum == FULL);
  assign en     = (add_i != '0);
  assign flag_o = flag_q;

  always_comb begin
    cnt_d  = sum[CW-1:0];
    flag_d = flag_q;
    if (done_o) begin
      cnt_d  = '0;
      // every processor has flipped to the same new sense: the inverse
      flag_d = ~flag_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < FULL);
  // R4
  flag_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (flag_q != $past(flag_q)));
  // R5
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(flag_q));
endmodule

// File: rtl/barrier_sync_unit.sv
module barrier_sync_unit #(
  parameter int P = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [P-1:0] arrive_i,
  output logic [P-1:0] depart_o
);
  localparam int CW = barrier_pkg::count_width(P);

  logic [P-1:0]  accept;
  logic [CW-1:0] add;
  logic          flag;
  logic          done;

  for (genvar g = 0; g < P; g++) begin : g_slot
    sense_slot u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .arrive_i (arrive_i[g]),
      .flag_i   (flag),
      .accept_o (accept[g]),
      .depart_o (depart_o[g])
    );
  end

  arrival_popcount #(.N(P), .CW(CW)) u_pop (
    .bits_i (accept),
    .sum_o  (add)
  );

  episode_ctrl #(.P(P), .CW(CW)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .add_i  (add),
    .flag_o (flag),
    .done_o (done)
  );

  // R4
  all_depart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depart_o != '0) |-> (&depart_o));
  // R4
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (&depart_o));
  // R6
  depart_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depart_o != '0) |-> (accept == '0));
endmodule

// File: tb/barrier_sync_unit_tb_top.sv
`timescale 1ns/1ps
module barrier_sync_unit_tb_top;
  localparam int P = 4;
  localparam logic [P-1:0] ALL = '1;

  typedef struct {
    logic [P-1:0] exp;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [P-1:0] arrive = '0;
  logic [P-1:0] depart;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  item_t sb[$];

  logic [P-1:0] m_wait = '0;
  bit           m_rel  = 0;

  always #2.5 clk = ~clk;

  barrier_sync_unit #(.P(P)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .arrive_i (arrive),
    .depart_o (depart)
  );

  // driver: apply one cycle of arrivals, predict the release seen after the edge
  task automatic drive(input logic [P-1:0] arr, input string tag);
    item_t it;
    logic [P-1:0] acc;
    @(negedge clk);
    arrive = arr;
    acc = arr & ~m_wait;
    if (m_rel) begin
      m_wait = '0;
      m_rel  = 0;
    end
    m_wait = m_wait | acc;
    if (m_wait == ALL) begin
      m_rel  = 1;
      it.exp = ALL;
    end else begin
      it.exp = '0;
    end
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare each cycle's output with the predicted item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (depart !== it.exp) begin
          errors++;
          $display("FAIL %s: depart=%b expected=%b", it.tag, depart, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (depart !== '0) begin
      errors++;
      $display("FAIL R1: depart=%b expected=%b", depart, {P{1'b0}});
    end
    rst_n = 1'b1;
    drive('0, "R1 idle");

    // R2 R5: one at a time, R4 completion on the last
    drive(4'b0001, "R2 first");
    drive(4'b0010, "R5 partial");
    drive(4'b0100, "R5 partial");
    drive(4'b1000, "R4 last");
    drive(4'b0000, "R8 after pulse");
    drive(4'b0000, "R8 idle");

    // R3: all in one cycle
    drive(4'b1111, "R3 together");
    drive(4'b0000, "R8 after pulse");

    // R6: repeats from waiting processors ignored
    drive(4'b0001, "R6 first");
    drive(4'b0001, "R6 repeat");
    drive(4'b0011, "R6 repeat mix");
    drive(4'b0101, "R6 repeat mix");
    drive(4'b1000, "R4 last");
    // R6: arrivals in the depart cycle ignored
    drive(4'b1111, "R6 in depart cycle");
    drive(4'b0000, "R6 no episode");

    // R3 groups, then R7 back-to-back
    drive(4'b0101, "R3 pair");
    drive(4'b1010, "R3 pair done");
    drive(4'b0000, "R7 pulse seen");
    drive(4'b1111, "R7 immediate");
    drive(4'b0000, "R7 pulse seen");
    drive(4'b0011, "R7 next");
    drive(4'b1100, "R7 next done");
    drive(4'b0000, "R7 pulse seen");
    drive(4'b0000, "R8 idle");
    drive(4'b0000, "R8 idle");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule